// File: doc/BRIEF.md
# Output Conflict Flag and Interrupt Unit

This unit collects single-cycle reports of output conflicts where no change occurs, one line per output. It holds each report as a sticky flag until software clears it. When any flag has its enable bit set, it raises one interrupt line. It also remembers which counter half caused the most recent illegal register write. Each half reports that error on its own pulse. When a word write succeeds for one half and fails for the other, only the failing half raises its pulse.

Software sees two registers through a simple port. `reg_sel`=0 selects the enable register, and `reg_sel`=1 selects the flag/error register. Reads are combinational from the stored state. Writes take effect at the next clock edge.

Two small state machines sit beside the flag bank.

The interrupt machine has two states, `IRQ_QUIET` and `IRQ_RAISED`. Its transitions are:
- quiet to raised, when an enabled flag is seen;
- raised to quiet, when no enabled flag is seen;
- each state to itself otherwise.

The error machine has four states: `ERR_NONE`, `ERR_LO`, `ERR_HI` and `ERR_BOTH`. Any error pulse moves it to the state that names exactly the halves pulsing in that cycle, whichever state it was in. With no pulse it stays where it is. Reset sends both machines to `IRQ_QUIET` and `ERR_NONE`.

Top module: `cfi_unit`

## Requirements
- R1: A 1 on `conflict[n]` at a clock edge sets flag n, which reads as bit n of the flag register from the next cycle on and stays set with no further pulse.
- R2: Writing the flag register (`reg_sel`=1) clears every flag n whose `wdata[n]` is 1. Flags whose `wdata[n]` is 0 are unchanged.
- R3: When a conflict pulse and a write-1 clear hit the same flag at the same edge, the flag ends set.
- R4: Writing the enable register (`reg_sel`=0) loads bits NUM_OUT-1:0 from `wdata`. Reading it returns those bits, with all higher bits reading 0.
- R5: `irq` is 1 in the cycle after an edge at which some bit n had both enable n and flag n at 1. It is 0 in the cycle after an edge at which no such bit existed.
- R6: In the flag register, bits 29:16 and any flag bit at or above NUM_OUT always read 0.
- R7: A pulse on `buserr_lo` alone sets bit 30 and clears bit 31 of the flag register from the next cycle on.
- R8: A pulse on `buserr_hi` alone sets bit 31 and clears bit 30 from the next cycle on. Pulses on both in the same cycle set both bits.
- R9: Bits 31:30 change only on an error pulse. Register writes, including writes of 1 to bits 31:30, leave them unchanged.
- R10: After reset, all flags, enables and error bits read 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conflict | input | NUM_OUT | Per-output no-change conflict pulse |
| buserr_lo | input | 1 | Illegal write to a low/unified-half register |
| buserr_hi | input | 1 | Illegal write to a high-half register |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects enable, 1 selects flag/error |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives a conflict pulse and a write-1 clear into the same bit at the same edge. A design that let the clear win would lose that event, and the flag would read 0.

It writes 1s to bits 31:30 and 0s to flags that are set. A design that treated the whole word as write-1-to-clear, or that cleared on any write, would show the error bits or the flags dropping.

It alternates error pulses from the two halves and also sends both in one cycle. A design that kept the stale bit for the other half would report two errors after the first alternation.

A long random run follows, with sparse conflicts and random enables, checked against a bench model every cycle. It catches an interrupt that is late by a cycle, that stays stuck high, or that ignores the enable mask.

// File: rtl/cfi_pkg.sv
package cfi_pkg;
    localparam int REG_W      = 32;
    localparam int MAX_OUT    = 16;
    localparam int ERRLO_BIT  = 30;
    localparam int ERRHI_BIT  = 31;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;

    typedef enum logic [1:0] {
        ERR_NONE = 2'b00,
        ERR_LO   = 2'b01,
        ERR_HI   = 2'b10,
        ERR_BOTH = 2'b11
    } err_state_t;
endpackage

// File: rtl/cfi_flag_bank.sv
module cfi_flag_bank #(
    parameter int NUM_OUT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OUT-1:0] conflict,
    input  logic               en_wr,
    input  logic               flag_wr,
    input  logic [NUM_OUT-1:0] wbits,
    output logic [NUM_OUT-1:0] flag_q,
    output logic [NUM_OUT-1:0] en_q,
    output logic               any_hit
);
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
                en_q[i]   <= 1'b0;
            end else begin
                if (conflict[i]) begin
                    flag_q[i] <= 1'b1;
                end else if (flag_wr && wbits[i]) begin
                    flag_q[i] <= 1'b0;
                end
                if (en_wr) begin
                    en_q[i] <= wbits[i];
                end
            end
        end
    end

    assign any_hit = |(flag_q & en_q);
endmodule

// File: rtl/cfi_irq_fsm.sv
module cfi_irq_fsm
    import cfi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_hit,
    output logic irq
);
    irq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (any_hit)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!any_hit) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            IRQ_RAISED: irq = 1'b1;
            default:    irq = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfi_err_fsm.sv
module cfi_err_fsm
    import cfi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic buserr_lo,
    input  logic buserr_hi,
    output logic err_lo,
    output logic err_hi
);
    err_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case ({buserr_hi, buserr_lo})
            2'b01:   state_d = ERR_LO;
            2'b10:   state_d = ERR_HI;
            2'b11:   state_d = ERR_BOTH;
            default: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ERR_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ERR_LO:   begin err_lo = 1'b1; err_hi = 1'b0; end
            ERR_HI:   begin err_lo = 1'b0; err_hi = 1'b1; end
            ERR_BOTH: begin err_lo = 1'b1; err_hi = 1'b1; end
            default:  begin err_lo = 1'b0; err_hi = 1'b0; end
        endcase
    end
endmodule

// File: rtl/cfi_unit.sv
module cfi_unit
    import cfi_pkg::*;
#(
    parameter int NUM_OUT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OUT-1:0] conflict,
    input  logic               buserr_lo,
    input  logic               buserr_hi,
    input  logic               wr_en,
    input  logic               reg_sel,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rdata,
    output logic               irq
);
    logic [NUM_OUT-1:0] flag_q;
    logic [NUM_OUT-1:0] en_q;
    logic               any_hit;
    logic               err_lo;
    logic               err_hi;
    logic               en_wr;
    logic               flag_wr;

    assign en_wr   = wr_en && !reg_sel;
    assign flag_wr = wr_en && reg_sel;

    cfi_flag_bank #(.NUM_OUT(NUM_OUT)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .conflict (conflict),
        .en_wr    (en_wr),
        .flag_wr  (flag_wr),
        .wbits    (wdata[NUM_OUT-1:0]),
        .flag_q   (flag_q),
        .en_q     (en_q),
        .any_hit  (any_hit)
    );

    cfi_irq_fsm u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_hit (any_hit),
        .irq     (irq)
    );

    cfi_err_fsm u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .buserr_lo (buserr_lo),
        .buserr_hi (buserr_hi),
        .err_lo    (err_lo),
        .err_hi    (err_hi)
    );

    always_comb begin
        rdata = '0;
        if (reg_sel) begin
            rdata[NUM_OUT-1:0] = flag_q;
            rdata[ERRLO_BIT]   = err_lo;
            rdata[ERRHI_BIT]   = err_hi;
        end else begin
            rdata[NUM_OUT-1:0] = en_q;
        end
    end
endmodule

// File: rtl/cfi_unit_chk.sv
module cfi_unit_chk
    import cfi_pkg::*;
#(
    parameter int NUM_OUT = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_OUT-1:0] conflict,
    input logic               buserr_lo,
    input logic               buserr_hi,
    input logic               wr_en,
    input logic               reg_sel,
    input logic [REG_W-1:0]   wdata,
    input logic [REG_W-1:0]   rdata,
    input logic               irq,
    input logic [NUM_OUT-1:0] flag_q,
    input logic [NUM_OUT-1:0] en_q
);
    logic [NUM_OUT-1:0] clr_mask;
    assign clr_mask = (wr_en && reg_sel) ? wdata[NUM_OUT-1:0] : '0;

    p_flag_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|conflict) |=> ((flag_q & $past(conflict)) == $past(conflict)));

    p_clear_only_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(flag_q) & ~flag_q) & ~$past(clr_mask)) == '0));

    p_irq_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_q & en_q)) |=> irq);

    p_irq_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flag_q & en_q)) |=> !irq);

    p_err_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (buserr_lo && !buserr_hi && reg_sel) |=> (!reg_sel || (rdata[ERRLO_BIT] && !rdata[ERRHI_BIT])));

    p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!buserr_lo && !buserr_hi && reg_sel) |=> (!reg_sel || $stable(rdata[ERRHI_BIT:ERRLO_BIT])));

    always_comb begin
        if (rst_n) begin
            p_reserved_zero_r6: assert (rdata[29:16] == '0);
        end
    end
endmodule

bind cfi_unit cfi_unit_chk #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conflict  (conflict),
    .buserr_lo (buserr_lo),
    .buserr_hi (buserr_hi),
    .wr_en     (wr_en),
    .reg_sel   (reg_sel),
    .wdata     (wdata),
    .rdata     (rdata),
    .irq       (irq),
    .flag_q    (flag_q),
    .en_q      (en_q)
);

// File: tb/cfi_unit_tb.sv
module cfi_unit_tb;
    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  conflict = '0;
    logic          buserr_lo = 1'b0;
    logic          buserr_hi = 1'b0;
    logic          wr_en = 1'b0;
    logic          reg_sel = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [N-1:0] m_flag = '0;
    logic [N-1:0] m_en = '0;
    logic         m_elo = 1'b0;
    logic         m_ehi = 1'b0;
    logic         m_irq = 1'b0;

    always #4 clk = ~clk;

    cfi_unit #(.NUM_OUT(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .conflict(conflict),
        .buserr_lo(buserr_lo), .buserr_hi(buserr_hi),
        .wr_en(wr_en), .reg_sel(reg_sel), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    function automatic logic [31:0] exp_read(input logic sel);
        logic [31:0] v;
        v = '0;
        if (sel) begin
            v[N-1:0] = m_flag;
            v[30] = m_elo;
            v[31] = m_ehi;
        end else begin
            v[N-1:0] = m_en;
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at a negedge, update model at the edge, compare at the next negedge.
    task automatic cycle(input logic [N-1:0] c, input logic lo, input logic hi,
                         input logic we, input logic sel, input logic [31:0] wd,
                         input string tag);
        logic [N-1:0] nf;
        logic [N-1:0] ne;
        logic nlo, nhi, nirq;
        conflict = c; buserr_lo = lo; buserr_hi = hi;
        wr_en = we; reg_sel = sel; wdata = wd;
        nirq = |(m_flag & m_en);
        nf = m_flag;
        if (we && sel) nf = nf & ~wd[N-1:0];
        nf = nf | c;
        ne = (we && !sel) ? wd[N-1:0] : m_en;
        nlo = m_elo; nhi = m_ehi;
        if (lo || hi) begin nlo = lo; nhi = hi; end
        @(posedge clk);
        m_flag = nf; m_en = ne; m_elo = nlo; m_ehi = nhi; m_irq = nirq;
        @(negedge clk);
        wr_en = 1'b0; conflict = '0; buserr_lo = 1'b0; buserr_hi = 1'b0;
        check({tag, " read"}, rdata, exp_read(sel));
        check("R5 irq", {31'b0, irq}, {31'b0, m_irq});
    endtask

    task automatic peek(input logic sel, input string tag);
        reg_sel = sel;
        #1;
        check(tag, rdata, exp_read(sel));
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        peek(1'b0, "R10 enable after reset");
        peek(1'b1, "R10 flags after reset");
        check("R10 irq after reset", {31'b0, irq}, 32'd0);

        // R4 enable write and readback, upper bits ignored
        cycle('0, 0, 0, 1, 0, 32'hFFFF_A5C3, "R4");
        // R1 flag set, sticky
        cycle(16'h0081, 0, 0, 0, 1, 32'h0, "R1 set");
        cycle('0, 0, 0, 0, 1, 32'h0, "R1 sticky");
        cycle('0, 0, 0, 0, 1, 32'h0, "R5 irq settle");
        // R2 write zero leaves flags, write one clears
        cycle('0, 0, 0, 1, 1, 32'h0000_0000, "R2 write zero");
        cycle('0, 0, 0, 1, 1, 32'h0000_0001, "R2 clear bit0");
        // R3 conflict wins over clear
        cycle(16'h0080, 0, 0, 1, 1, 32'h0000_0080, "R3 set beats clear");
        // R6 reserved bits ignore writes
        cycle('0, 0, 0, 1, 1, 32'h3FFF_0000, "R6 reserved");
        // R7 low error
        cycle('0, 1, 0, 0, 1, 32'h0, "R7 lo error");
        // R8 high error clears low
        cycle('0, 0, 1, 0, 1, 32'h0, "R8 hi error");
        cycle('0, 1, 1, 0, 1, 32'h0, "R8 both errors");
        // R9 writes of ones to 31:30 have no effect
        cycle('0, 0, 0, 1, 1, 32'hC000_0000, "R9 write err bits");
        cycle('0, 1, 0, 0, 1, 32'h0, "R7 lo after both");
        // R5 irq drops when enable cleared
        cycle('0, 0, 0, 1, 0, 32'h0, "R5 disable");
        cycle('0, 0, 0, 0, 0, 32'h0, "R5 irq low");

        for (int k = 0; k < 400; k++) begin
            logic [N-1:0] c;
            c = N'($urandom & $urandom & $urandom & $urandom);
            cycle(c, ($urandom % 10) == 0, ($urandom % 10) == 0,
                  ($urandom % 3) == 0, $urandom % 2, $urandom, "R1 R2 random");
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule